// File: doc/BRIEF.md
# Variable Shift and Rotate Execution Unit

This block executes the variable-count shift and rotate group of a two-byte instruction. The first byte is an opcode and the second is an operand-specifier byte. Two opcode values are handled, one for a byte-wide operand and one for a 16-bit operand. A single opcode covers eight operation slots. The middle three bits of the specifier byte pick the operation; they do not name a register. The shift amount is never encoded in the instruction. It always comes from a dedicated count register, of which only the low five bits are used.

The unit works on a register operand value supplied by the surrounding datapath, together with the incoming carry flag. It returns the result and the new carry flag. Operations covered: plain rotates, rotates through carry, left shift, logical right shift and arithmetic right shift. The left shift is reachable through two slot values. When the specifier byte's top two bits indicate a memory operand, the unit still computes on the supplied value and raises a memory-operand flag. Opcodes outside the group are reported as illegal.

The computation is combinational. Its outputs are captured in a register stage that loads only when the input strobe is high.

Top module: `vshift_unit`

## Requirements
- R1: An opcode other than 0xD2 or 0xD3 loads illegal=1, result=0, carry_out=carry_in and mem_operand=0. Opcodes 0xD2 and 0xD3 load illegal=0.
- R2: Bits [5:3] of `modrm` select the operation: 0 rotate left, 1 rotate right, 2 rotate left through carry, 3 rotate right through carry, 4 shift left, 5 logical shift right, 6 shift left, 7 arithmetic shift right.
- R3: The count is `count_reg[4:0]`; bits [7:5] are ignored. A count of zero returns the operand unchanged and carry_out equal to carry_in, for every operation.
- R4: Plain rotates use the count modulo the operand width. For rotate left, carry_out equals the result LSB. For rotate right, it equals the result MSB.
- R5: Rotates through carry rotate the operand and carry_in together as a width+1 bit quantity, with the count taken modulo width+1. carry_out is the bit that lands in the carry position.
- R6: Shift left and logical shift right fill with zeros. carry_out is the last bit shifted out. Counts at or above the width give a zero result.
- R7: Arithmetic shift right fills with the sign bit. Counts at or above the width give all sign bits, with carry_out equal to the sign.
- R8: Slot values 4 and 6 give identical result and carry_out for identical inputs.
- R9: For opcodes 0xD2 and 0xD3, mem_operand is 1 exactly when `modrm[7:6]` is not 2'b11. The result is computed from `operand` either way.
- R10: result, carry_out, illegal and mem_operand load on a rising clock edge where in_valid is 1, and hold otherwise. out_valid is in_valid delayed by one clock. An active-low reset clears all outputs to 0.
- R11: Opcode 0xD2 operates on `operand[7:0]` and drives result[15:8] to zero. Opcode 0xD3 operates on all 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Load strobe for the output stage |
| opcode | input | 8 | Instruction opcode byte |
| modrm | input | 8 | Operand-specifier byte (mode, slot, r/m) |
| operand | input | 16 | Register operand value |
| count_reg | input | 8 | Low byte of the count register |
| carry_in | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Output stage was loaded on the last edge |
| result | output | 16 | Shift or rotate result |
| carry_out | output | 1 | New carry flag |
| illegal | output | 1 | Opcode not in this group |
| mem_operand | output | 1 | Specifier names a memory operand |

## Verification
Two functions can fall in one instruction. A memory-mode specifier raises mem_operand, and a shift or rotate is computed on the supplied operand value in the same load. The random stimulus draws the whole specifier byte uniformly, so memory modes combine freely with every slot, with counts of zero, and with counts past the width. Each load is judged against a bench model. The model applies the operation one bit per step, and the flag is judged from the mode bits alone; both must be right on the same edge.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
   typedef enum logic [2:0] {
      OP_ROL = 3'd0,
      OP_ROR = 3'd1,
      OP_RCL = 3'd2,
      OP_RCR = 3'd3,
      OP_SHL = 3'd4,
      OP_SHR = 3'd5,
      OP_SAL = 3'd6,
      OP_SAR = 3'd7
   } vsr_op_e;

   localparam logic [7:0] OPC_BYTE = 8'hD2;
   localparam logic [7:0] OPC_WORD = 8'hD3;
   localparam logic [1:0] MODE_REG = 2'b11;
endpackage

// File: rtl/vsr_decode.sv
module vsr_decode
   import vsr_pkg::*;
#(
   parameter logic [7:0] OPC_N = OPC_BYTE,
   parameter logic [7:0] OPC_W = OPC_WORD
) (
   input  logic [7:0] opcode,
   input  logic [7:0] modrm,
   output vsr_op_e    op,
   output logic       is_wide,
   output logic       legal,
   output logic       mem_op
);
   logic [2:0] slot;
   logic [1:0] mode;

   if (OPC_N == OPC_W) begin : g_bad_opc
      $error("vsr_decode: the two opcodes must differ");
   end

   always_comb begin
      slot    = modrm[5:3];
      mode    = modrm[7:6];
      is_wide = (opcode == OPC_W);
      legal   = (opcode == OPC_N) || (opcode == OPC_W);
      mem_op  = legal && (mode != MODE_REG);
      // slot 6 folds onto slot 4: left shifts have one datapath
      if (slot == 3'd6) op = OP_SHL;
      else              op = vsr_op_e'(slot);
   end
endmodule

// File: rtl/vsr_core.sv
module vsr_core
   import vsr_pkg::*;
#(
   parameter int W  = 8,
   parameter int CW = 5
) (
   input  vsr_op_e         op,
   input  logic [W-1:0]    a,
   input  logic [CW-1:0]   cnt,
   input  logic            cin,
   output logic [W-1:0]    res,
   output logic            cout
);
   localparam int W2 = 2 * W;
   localparam int WR = W + 1;

   if (W < 2) begin : g_bad_w
      $error("vsr_core: width must be at least 2");
   end

   int unsigned            rot_k;
   int unsigned            rc_k;
   logic [W2-1:0]          rl_d, rr_d, sl_d, sr_d;
   logic signed [W2-1:0]   sa_d;
   logic [WR-1:0]          xc;
   logic [2*WR-1:0]        rcl_d, rcr_d;

   always_comb begin
      rot_k = 32'(cnt) % W;
      rc_k  = 32'(cnt) % WR;
      xc    = {cin, a};
      rl_d  = {a, a} << rot_k;
      rr_d  = {a, a} >> rot_k;
      rcl_d = {xc, xc} << rc_k;
      rcr_d = {xc, xc} >> rc_k;
      sl_d  = {{W{1'b0}}, a} << cnt;
      sr_d  = {a, {W{1'b0}}} >> cnt;
      sa_d  = $signed({a, {W{1'b0}}}) >>> cnt;

      unique case (op)
         OP_ROL: begin res = rl_d[W2-1:W];   cout = rl_d[W];       end
         OP_ROR: begin res = rr_d[W-1:0];    cout = rr_d[W-1];     end
         OP_RCL: begin res = rcl_d[2*WR-2:WR]; cout = rcl_d[2*WR-1]; end
         OP_RCR: begin res = rcr_d[W-1:0];   cout = rcr_d[W];      end
         OP_SHL, OP_SAL: begin res = sl_d[W-1:0]; cout = sl_d[W];  end
         OP_SHR: begin res = sr_d[W2-1:W];   cout = sr_d[W-1];     end
         OP_SAR: begin res = sa_d[W2-1:W];   cout = sa_d[W-1];     end
         default: begin res = a;             cout = cin;           end
      endcase

      if (cnt == '0) begin
         res  = a;
         cout = cin;
      end
   end
endmodule

// File: rtl/vshift_unit.sv
module vshift_unit
   import vsr_pkg::*;
#(
   parameter int NARROW_W = 8,
   parameter int WIDE_W   = 16,
   parameter int CNT_W    = 5,
   parameter int CREG_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        opcode,
   input  logic [7:0]        modrm,
   input  logic [WIDE_W-1:0] operand,
   input  logic [CREG_W-1:0] count_reg,
   input  logic              carry_in,
   output logic              out_valid,
   output logic [WIDE_W-1:0] result,
   output logic              carry_out,
   output logic              illegal,
   output logic              mem_operand
);
   localparam int NSIZE = 2;

   if (NARROW_W >= WIDE_W) begin : g_bad_sizes
      $error("vshift_unit: NARROW_W must be below WIDE_W");
   end
   if (CNT_W > CREG_W) begin : g_bad_cnt
      $error("vshift_unit: CNT_W cannot exceed CREG_W");
   end

   vsr_op_e           op;
   logic              is_wide, legal, mem_op;
   logic [CNT_W-1:0]  cnt;
   logic [WIDE_W-1:0] core_res [NSIZE];
   logic              core_cf  [NSIZE];
   logic [WIDE_W-1:0] nxt_res;
   logic              nxt_cf;

   assign cnt = count_reg[CNT_W-1:0];

   vsr_decode u_dec (
      .opcode (opcode),
      .modrm  (modrm),
      .op     (op),
      .is_wide(is_wide),
      .legal  (legal),
      .mem_op (mem_op)
   );

   for (genvar gi = 0; gi < NSIZE; gi++) begin : g_size
      localparam int SW = (gi == 0) ? NARROW_W : WIDE_W;
      logic [SW-1:0] r;
      vsr_core #(.W(SW), .CW(CNT_W)) u_core (
         .op  (op),
         .a   (operand[SW-1:0]),
         .cnt (cnt),
         .cin (carry_in),
         .res (r),
         .cout(core_cf[gi])
      );
      assign core_res[gi] = WIDE_W'(r);
   end

   always_comb begin
      if (!legal) begin
         nxt_res = '0;
         nxt_cf  = carry_in;
      end else if (is_wide) begin
         nxt_res = core_res[1];
         nxt_cf  = core_cf[1];
      end else begin
         nxt_res = core_res[0];
         nxt_cf  = core_cf[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         result      <= '0;
         carry_out   <= 1'b0;
         illegal     <= 1'b0;
         mem_operand <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result      <= nxt_res;
            carry_out   <= nxt_cf;
            illegal     <= !legal;
            mem_operand <= mem_op;
         end
      end
   end

   p_illegal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid) && $past(opcode) != OPC_BYTE && $past(opcode) != OPC_WORD)
      |-> (illegal && result == '0 && !mem_operand));

   p_zero_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid) && $past(opcode) == OPC_WORD && $past(count_reg[CNT_W-1:0]) == '0)
      |-> (result == $past(operand) && carry_out == $past(carry_in)));

   p_rot_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid) && $past(opcode) == OPC_WORD && $past(modrm[5:4]) == 2'b00)
      |-> ($countones(result) == $countones($past(operand))));

   p_mem_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid) && $past(opcode) == OPC_WORD)
      |-> (mem_operand == ($past(modrm[7:6]) != MODE_REG)));

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> ($stable(result) && $stable(carry_out) && $stable(illegal)));

   p_narrow_hi_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid) && $past(opcode) == OPC_BYTE)
      |-> (result[WIDE_W-1:NARROW_W] == '0));
endmodule

// File: tb/vshift_unit_tb.sv
module vshift_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  opcode = 8'h00;
   logic [7:0]  modrm = 8'h00;
   logic [15:0] operand = 16'h0000;
   logic [7:0]  count_reg = 8'h00;
   logic        carry_in = 1'b0;
   logic        out_valid;
   logic [15:0] result;
   logic        carry_out, illegal, mem_operand;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   vshift_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
      .modrm(modrm), .operand(operand), .count_reg(count_reg),
      .carry_in(carry_in), .out_valid(out_valid), .result(result),
      .carry_out(carry_out), .illegal(illegal), .mem_operand(mem_operand)
   );

   // model: {illegal, mem, carry, result[15:0]}, one bit per step
   function automatic logic [18:0] model(input logic [7:0] opc, input logic [7:0] mrm,
                                         input logic [15:0] v, input logic [7:0] cr,
                                         input logic ci);
      int w, c;
      logic [16:0] a, mask;
      logic cf, b;
      if (opc != 8'hD2 && opc != 8'hD3) return {1'b1, 1'b0, ci, 16'h0};
      w = (opc == 8'hD2) ? 8 : 16;
      mask = (17'd1 << w) - 17'd1;
      a = {1'b0, v} & mask;
      cf = ci;
      c = int'(cr[4:0]);
      for (int i = 0; i < c; i++) begin
         case (mrm[5:3])
            3'd0: begin b = a[w-1]; a = ((a << 1) | 17'(b)) & mask; cf = b; end
            3'd1: begin b = a[0];   a = (a >> 1) | (17'(b) << (w-1));  cf = b; end
            3'd2: begin b = a[w-1]; a = ((a << 1) | 17'(cf)) & mask; cf = b; end
            3'd3: begin b = a[0];   a = (a >> 1) | (17'(cf) << (w-1)); cf = b; end
            3'd4, 3'd6: begin cf = a[w-1]; a = (a << 1) & mask; end
            3'd5: begin cf = a[0]; a = a >> 1; end
            default: begin cf = a[0]; a = (a >> 1) | (17'(a[w-1]) << (w-1)); end
         endcase
      end
      return {1'b0, (mrm[7:6] != 2'b11), cf, a[15:0]};
   endfunction

   function automatic string tag_of(input logic [7:0] opc, input logic [7:0] mrm,
                                    input logic [7:0] cr);
      if (opc != 8'hD2 && opc != 8'hD3) return "R1";
      if (cr[4:0] == 5'd0) return "R3";
      if (opc == 8'hD2 && mrm[5:3] == 3'd0) return "R11";
      case (mrm[5:3])
         3'd0, 3'd1: return "R4";
         3'd2, 3'd3: return "R5";
         3'd7: return "R7";
         3'd6: return "R2";
         default: return "R6";
      endcase
   endfunction

   task automatic check(input string tag, input logic [18:0] got, input logic [18:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got ill=%0b mem=%0b cf=%0b res=%04h, expected ill=%0b mem=%0b cf=%0b res=%04h",
                  tag, got[18], got[17], got[16], got[15:0], exp[18], exp[17], exp[16], exp[15:0]);
      end
   endtask

   function automatic logic [18:0] outs();
      return {illegal, mem_operand, carry_out, result};
   endfunction

   logic [18:0] last_exp;

   task automatic apply(input logic [7:0] opc, input logic [7:0] mrm, input logic [15:0] v,
                        input logic [7:0] cr, input logic ci, input string tag);
      @(negedge clk);
      in_valid = 1'b1; opcode = opc; modrm = mrm; operand = v; count_reg = cr; carry_in = ci;
      @(negedge clk);
      last_exp = model(opc, mrm, v, cr, ci);
      check(tag, outs(), last_exp);
      if (out_valid !== 1'b1) begin
         n_bad++;
         $display("FAIL R10: out_valid got %0b expected 1", out_valid);
      end
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [18:0] r4, r6;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R10 reset", {out_valid, outs()} , 20'h0);
      rst_n = 1'b1;

      // directed corners: every slot, both sizes, boundary counts
      for (int s = 0; s < 8; s++) begin
         for (int z = 0; z < 2; z++) begin
            logic [7:0] opc = (z == 0) ? 8'hD2 : 8'hD3;
            int w = (z == 0) ? 8 : 16;
            int cl[7] = '{0, 1, w - 1, w, w + 1, 31, 32 + 3};
            for (int k = 0; k < 7; k++) begin
               for (int ci = 0; ci < 2; ci++) begin
                  apply(opc, {2'b11, 3'(s), 3'b000}, 16'hB481, 8'(cl[k]), 1'(ci),
                        tag_of(opc, {2'b11, 3'(s), 3'b000}, 8'(cl[k])));
               end
            end
         end
      end

      // R3: high count bits ignored
      apply(8'hD3, 8'hE8, 16'h8001, 8'hE0, 1'b1, "R3 masked zero");
      apply(8'hD3, 8'hC0, 16'h1234, 8'hA4, 1'b0, "R3 masked four");

      // R8: slots 4 and 6 agree
      for (int t = 0; t < 20; t++) begin
         logic [15:0] v = 16'($urandom);
         logic [7:0]  cr = 8'($urandom);
         logic        ci = 1'($urandom);
         apply(8'hD3, 8'hE0, v, cr, ci, "R6");
         r4 = outs();
         apply(8'hD3, 8'hF0, v, cr, ci, "R2");
         r6 = outs();
         check("R8 alias", r6, r4);
      end

      // R1 and R9: illegal opcodes, memory modes
      apply(8'hD0, 8'hC0, 16'hFFFF, 8'h03, 1'b1, "R1 near opcode");
      apply(8'hD1, 8'h05, 16'h00FF, 8'h02, 1'b0, "R1 mem ignored");
      apply(8'hD3, 8'h3D, 16'h8421, 8'h05, 1'b0, "R9 mem mode 0");
      apply(8'hD2, 8'h4F, 16'hFF81, 8'h03, 1'b1, "R9 mem mode 1");

      // R10: hold when strobe low
      @(negedge clk);
      in_valid = 1'b0; opcode = 8'hD3; modrm = 8'hC0; operand = 16'h5A5A; count_reg = 8'h07;
      @(negedge clk);
      check("R10 hold", outs(), last_exp);
      if (out_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R10: out_valid got %0b expected 0", out_valid);
      end

      // random mix
      for (int t = 0; t < 3000; t++) begin
         logic [7:0] opc;
         logic [7:0] mrm = 8'($urandom);
         logic [7:0] cr  = 8'($urandom);
         int sel = int'($urandom % 20);
         opc = (sel == 0) ? 8'($urandom) : ((sel < 10) ? 8'hD2 : 8'hD3);
         apply(opc, mrm, 16'($urandom), cr, 1'($urandom), tag_of(opc, mrm, cr));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule